// File: doc/BRIEF.md
# TLB-miss context register updater

This block holds two translation-context registers of a 64-bit memory management unit: the page-pair tag register (EntryHi) and the extended context register (XContext). When an address-translation exception is signalled, it loads both registers in a single clock cycle from the faulting virtual address. Software can then use them to locate the page table entry for the missing page without decoding the address itself.

On an exception, EntryHi keeps its address-space identifier and takes the virtual page-pair number from the faulting address. It is then trimmed to the implemented segment bits. XContext keeps its software-owned page-table base field. Below that field it receives the two region bits and the page-pair number, packed at positions set by the `SEG_BITS` parameter. Its lowest four bits are cleared.

Between exceptions, software loads either register through a one-word write port and reads either register back through a select input. The page size is fixed at 4 KiB, and `SEG_BITS` may range from 40 to 48.

Top module: `tlbx_ctx_update`

## Requirements
- R1: While `rst` is high at a clock edge, both registers become zero, and a software write in that cycle is discarded.
- R2: One edge after `exc_valid`, EntryHi bits 7:0 equal their previous value, and EntryHi bits 12:8 are zero.
- R3: One edge after `exc_valid`, EntryHi bits 63:62 and bits SEG_BITS-1 down to 13 equal the same bits of `exc_vaddr`, and EntryHi bits 61 down to SEG_BITS are zero.
- R4: One edge after `exc_valid`, XContext bits SEG_BITS-8 and SEG_BITS-9 hold `exc_vaddr` bits 63 and 62 respectively.
- R5: One edge after `exc_valid`, XContext bits SEG_BITS-10 down to 4 hold `exc_vaddr` bits SEG_BITS-1 down to 13.
- R6: One edge after `exc_valid`, XContext bits 63 down to SEG_BITS-7 equal their previous value.
- R7: One edge after `exc_valid`, XContext bits 3:0 are zero.
- R8: With `sw_we` high and `exc_valid` low, the full 64-bit `sw_wdata` is stored at the next edge: into EntryHi when `sw_sel`=0, and into XContext when `sw_sel`=1. The other register is unchanged.
- R9: When `exc_valid` and `sw_we` are high in the same cycle, the software write is dropped, and both registers take their exception values.
- R10: `rd_data` shows EntryHi when `rd_sel`=0 and XContext when `rd_sel`=1, combinationally.
- R11: With `exc_valid` and `sw_we` both low, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Translation exception strobe |
| exc_vaddr | input | 64 | Faulting virtual address |
| sw_we | input | 1 | Software write enable |
| sw_sel | input | 1 | Write target: 0 EntryHi, 1 XContext |
| sw_wdata | input | 64 | Software write data |
| rd_sel | input | 1 | Read select: 0 EntryHi, 1 XContext |
| rd_data | output | 64 | Selected register value |
| entryhi_o | output | 64 | Current EntryHi |
| xctx_o | output | 64 | Current XContext |

## Verification
On every cycle, the assertions check the following per-field rules after an exception:
- the address-space identifier and the page-table base are kept;
- the region bits and the page-pair number land in their XContext slots;
- the low XContext bits and the unimplemented EntryHi bits are zero.

They also check that both registers hold when idle, and that reset clears them.

Only the bench's scenarios show the following:
- full 64-bit values against an independent model;
- combinational read-back;
- the dropped write when a software write and an exception collide;
- the behaviour of each address bit, which the bench covers with walking single-bit addresses across a non-default `SEG_BITS`.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int unsigned VA_W       = 64;
    localparam int unsigned ASID_W     = 8;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned VPN2_LSB   = PAGE_SHIFT + 1;
    localparam int unsigned REGION_W   = 2;
    localparam int unsigned XCTX_LOW_W = 4;

    typedef logic [VA_W-1:0] word_t;

    typedef enum logic {
        CSEL_ENTRYHI = 1'b0,
        CSEL_XCTX    = 1'b1
    } ctx_sel_e;

    typedef struct packed {
        logic  valid;
        word_t vaddr;
    } miss_evt_t;

    typedef struct packed {
        logic     en;
        ctx_sel_e sel;
        word_t    data;
    } sw_wr_t;

    // Ones on every bit at or above lsb.
    function automatic word_t ones_from(int unsigned lsb);
        word_t m;
        for (int i = 0; i < int'(VA_W); i++) begin
            m[i] = (i >= int'(lsb));
        end
        return m;
    endfunction

    // Implemented segment bits plus the two region bits at the top.
    function automatic word_t seg_mask(int unsigned seg);
        word_t m;
        for (int i = 0; i < int'(VA_W); i++) begin
            m[i] = (i < int'(seg)) || (i >= int'(VA_W - REGION_W));
        end
        return m;
    endfunction

endpackage

// File: rtl/tlbx_entryhi_calc.sv
module tlbx_entryhi_calc
    import tlbx_pkg::*;
#(
    parameter int unsigned SEG_BITS = 48
) (
    input  word_t cur,
    input  word_t vaddr,
    output word_t nxt
);
    localparam word_t SEG_MASK  = seg_mask(SEG_BITS);
    localparam word_t VPN2_MASK = ones_from(VPN2_LSB);
    localparam word_t ASID_MASK = ~ones_from(ASID_W);

    word_t raw;

    always_comb begin
        raw = (cur & ASID_MASK) | (vaddr & VPN2_MASK);
        nxt = raw & SEG_MASK;
    end

endmodule

// File: rtl/tlbx_xctx_calc.sv
module tlbx_xctx_calc
    import tlbx_pkg::*;
#(
    parameter int unsigned SEG_BITS = 48
) (
    input  logic [VA_W-SEG_BITS+6:0]        cur_base,
    input  logic [REGION_W-1:0]             region,
    input  logic [SEG_BITS-VPN2_LSB-1:0]    bvpn2,
    output word_t                           nxt
);
    localparam int unsigned BVPN_W     = SEG_BITS - VPN2_LSB;
    localparam int unsigned REGION_LSB = XCTX_LOW_W + BVPN_W;
    localparam int unsigned BASE_LSB   = REGION_LSB + REGION_W;

    always_comb begin
        nxt = '0;
        nxt[VA_W-1:BASE_LSB]            = cur_base;
        nxt[BASE_LSB-1:REGION_LSB]      = region;
        nxt[REGION_LSB-1:XCTX_LOW_W]    = bvpn2;
    end

endmodule

// File: rtl/tlbx_ctx_reg.sv
module tlbx_ctx_reg
    import tlbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  miss_ld,
    input  word_t miss_val,
    input  logic  wr_ld,
    input  word_t wr_val,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (miss_ld) begin
            q <= miss_val;
        end else if (wr_ld) begin
            q <= wr_val;
        end
    end

endmodule

// File: rtl/tlbx_ctx_update.sv
module tlbx_ctx_update
    import tlbx_pkg::*;
#(
    parameter int unsigned SEG_BITS = 48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        exc_valid,
    input  logic [63:0] exc_vaddr,
    input  logic        sw_we,
    input  logic        sw_sel,
    input  logic [63:0] sw_wdata,
    input  logic        rd_sel,
    output logic [63:0] rd_data,
    output logic [63:0] entryhi_o,
    output logic [63:0] xctx_o
);
    localparam int unsigned BVPN_W     = SEG_BITS - VPN2_LSB;
    localparam int unsigned REGION_LSB = XCTX_LOW_W + BVPN_W;
    localparam int unsigned BASE_LSB   = REGION_LSB + REGION_W;

    generate
        if (SEG_BITS < 40 || SEG_BITS > 48) begin : g_bad_seg
            $error("SEG_BITS outside 40..48");
        end
    endgenerate

    miss_evt_t evt;
    sw_wr_t    wr;
    word_t     eh_q, xc_q, eh_nxt, xc_nxt;
    logic      wr_eh, wr_xc;

    always_comb begin
        evt.valid = exc_valid;
        evt.vaddr = exc_vaddr;
        wr.en     = sw_we;
        wr.sel    = ctx_sel_e'(sw_sel);
        wr.data   = sw_wdata;
        wr_eh     = wr.en && (wr.sel == CSEL_ENTRYHI);
        wr_xc     = wr.en && (wr.sel == CSEL_XCTX);
    end

    tlbx_entryhi_calc #(.SEG_BITS(SEG_BITS)) u_eh_calc (
        .cur   (eh_q),
        .vaddr (evt.vaddr),
        .nxt   (eh_nxt)
    );

    tlbx_xctx_calc #(.SEG_BITS(SEG_BITS)) u_xc_calc (
        .cur_base (xc_q[VA_W-1:BASE_LSB]),
        .region   (evt.vaddr[VA_W-1:VA_W-REGION_W]),
        .bvpn2    (evt.vaddr[SEG_BITS-1:VPN2_LSB]),
        .nxt      (xc_nxt)
    );

    tlbx_ctx_reg u_eh_reg (
        .clk      (clk),
        .rst      (rst),
        .miss_ld  (evt.valid),
        .miss_val (eh_nxt),
        .wr_ld    (wr_eh),
        .wr_val   (wr.data),
        .q        (eh_q)
    );

    tlbx_ctx_reg u_xc_reg (
        .clk      (clk),
        .rst      (rst),
        .miss_ld  (evt.valid),
        .miss_val (xc_nxt),
        .wr_ld    (wr_xc),
        .wr_val   (wr.data),
        .q        (xc_q)
    );

    always_comb begin
        entryhi_o = eh_q;
        xctx_o    = xc_q;
        rd_data   = (ctx_sel_e'(rd_sel) == CSEL_XCTX) ? xc_q : eh_q;
    end

    // Register-level checks next to the update logic.
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (entryhi_o == '0) && (xctx_o == '0));

    a_r2_asid_kept: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (entryhi_o[ASID_W-1:0] == $past(entryhi_o[ASID_W-1:0]))
                      && (entryhi_o[VPN2_LSB-1:ASID_W] == '0));

    a_r3_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (entryhi_o[VA_W-REGION_W-1:SEG_BITS] == '0)
                      && (entryhi_o[VA_W-1:VA_W-REGION_W] == $past(exc_vaddr[VA_W-1:VA_W-REGION_W])));

    a_r4_region_slot: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> xctx_o[BASE_LSB-1:REGION_LSB] == $past(exc_vaddr[VA_W-1:VA_W-REGION_W]));

    a_r5_bvpn2_slot: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> xctx_o[REGION_LSB-1:XCTX_LOW_W] == $past(exc_vaddr[SEG_BITS-1:VPN2_LSB]));

    a_r6_base_kept: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> xctx_o[VA_W-1:BASE_LSB] == $past(xctx_o[VA_W-1:BASE_LSB]));

    a_r7_low_zero: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> xctx_o[XCTX_LOW_W-1:0] == '0);

    a_r9_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && sw_we && sw_sel) |=> xctx_o[XCTX_LOW_W-1:0] == '0);

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!exc_valid && !sw_we) |=> $stable(entryhi_o) && $stable(xctx_o));

endmodule

// File: tb/tlbx_ctx_update_bench.sv
module tlbx_ctx_update_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SEG = 44;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_valid = 1'b0;
    logic [63:0] exc_vaddr = '0;
    logic        sw_we = 1'b0;
    logic        sw_sel = 1'b0;
    logic [63:0] sw_wdata = '0;
    logic        rd_sel = 1'b0;
    logic [63:0] rd_data, entryhi_o, xctx_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] eh;
        logic [63:0] xc;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] m_eh = '0;
    logic [63:0] m_xc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbx_ctx_update #(.SEG_BITS(SEG)) u_tlbx_ctx_update (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_vaddr(exc_vaddr),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .rd_sel(rd_sel),
        .rd_data(rd_data), .entryhi_o(entryhi_o), .xctx_o(xctx_o)
    );

    function automatic logic [63:0] exp_eh(logic [63:0] old, logic [63:0] va);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            if (i < 8)        r[i] = old[i];
            else if (i < 13)  r[i] = 1'b0;
            else if (i >= 62) r[i] = va[i];
            else if (i < SEG) r[i] = va[i];
            else              r[i] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_xc(logic [63:0] old, logic [63:0] va);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            if (i >= SEG - 7)      r[i] = old[i];
            else if (i >= SEG - 9) r[i] = va[62 + i - (SEG - 9)];
            else if (i >= 4)       r[i] = va[i - 4 + 13];
            else                   r[i] = 1'b0;
        end
        return r;
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic drive(bit exc, logic [63:0] va, bit we, bit sel,
                         logic [63:0] wd, string tag);
        exp_t e;
        @(negedge clk);
        exc_valid = exc; exc_vaddr = va;
        sw_we = we; sw_sel = sel; sw_wdata = wd;
        if (exc) begin
            e.eh = exp_eh(m_eh, va);
            e.xc = exp_xc(m_xc, va);
        end else begin
            e.eh = (we && !sel) ? wd : m_eh;
            e.xc = (we && sel)  ? wd : m_xc;
        end
        m_eh = e.eh; m_xc = e.xc;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(string tag);
        drive(1'b0, 64'h0, 1'b0, 1'b0, 64'h0, tag);
    endtask

    task automatic readback(bit s, string tag);
        @(negedge clk);
        exc_valid = 1'b0; sw_we = 1'b0;
        rd_sel = s;
        #1;
        check64(tag, rd_data, s ? m_xc : m_eh);
    endtask

    // Monitor: compare a quarter period after each rising edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check64({e.tag, " EntryHi"}, entryhi_o, e.eh);
                check64({e.tag, " XContext"}, xctx_o, e.xc);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: a write during reset is discarded
        sw_we = 1'b1; sw_sel = 1'b1; sw_wdata = 64'hDEAD_BEEF_0000_1111;
        repeat (3) @(negedge clk);
        sw_we = 1'b0;
        rst = 1'b0;
        check64("R1 reset EntryHi", entryhi_o, 64'h0);
        check64("R1 reset XContext", xctx_o, 64'h0);

        drive(0, 64'h0, 1, 0, '1, "R8 write EntryHi");
        drive(0, 64'h0, 1, 1, '1, "R8 write XContext");
        readback(0, "R10 read EntryHi");
        readback(1, "R10 read XContext");

        drive(1, '1, 0, 0, 64'h0, "R2/R3/R4/R5/R6/R7 all-ones address");
        idle("R11 hold");
        idle("R11 hold again");
        drive(1, 64'h0, 0, 0, 64'h0, "R4/R5/R7 zero address");
        drive(1, 64'h8000_0000_0000_2000, 0, 0, 64'h0, "R4 region two");
        drive(1, 64'h4000_0000_0000_E000, 0, 0, 64'h0, "R4 region one");
        drive(0, 64'h0, 1, 1, 64'h1234_5678_9ABC_DEF0, "R8 XContext pattern");
        drive(0, 64'h0, 1, 0, 64'h0F0F_0F0F_0F0F_0FA5, "R8 EntryHi pattern");
        drive(1, 64'hA5A5_5A5A_C3C3_3C3C, 0, 0, 64'h0, "R2/R6 pattern address");
        drive(1, 64'hC000_0FFF_0000_F000, 1, 0, 64'h1111_2222_3333_4444, "R9 collide EntryHi");
        drive(1, 64'h3FFF_F000_1234_5000, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R9 collide XContext");
        idle("R11 hold after collide");
        readback(0, "R10 read EntryHi after");
        readback(1, "R10 read XContext after");

        for (int k = 0; k < 64; k++) begin
            drive(1, 64'h1 << k, 0, 0, 64'h0, "R3/R5 walking bit");
        end
        idle("R11 final hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule